// File: doc/BRIEF.md
# Burst Motion Report Reader

This block is the controller side of a serial link to a motion sensor. A single request fetches a whole motion report in one burst transaction. On `start_i` the block lowers chip select and shifts out the burst register address, most significant bit first, on a bidirectional data line. It then holds the serial clock high for a programmable settling gap. After the gap it clocks in between one and seven report bytes back to back, with no pause between them.

After the last requested byte, chip select goes high and stays high for a programmable exit time. Only then does the block report completion with a one-cycle `done_o` strobe, and only then does it take a new request. Received bytes land in a parallel output array, one slot per byte, in arrival order. The serial clock half-period, the settling gap and the exit time are parameters counted in system clock cycles (`SCLK_HALF`, `SRAD_CYC`, `EXIT_CYC`).

Top module: `burst_motion_reader`

## Requirements
- R1: After reset, and whenever no transaction is active, `cs_n_o` is 1, `sclk_o` is 1, `busy_o` is 0 and `done_o` is 0. Reset clears `data_o` to zero.
- R2: A `start_i` sampled high while idle starts a transaction. In the next cycle `cs_n_o` is 0 and `busy_o` is 1. The block then drives `BURST_ADDR` (default 8'h63) on `sdio_io`, MSB first, one bit per period of 2*`SCLK_HALF` cycles. Each bit period has `sclk_o` low for the first half and high for the second.
- R3: After the eighth address bit, `sclk_o` stays high with `cs_n_o` low for exactly `SRAD_CYC` cycles before the low half of the first data bit.
- R4: Data bits are clocked with the same bit period, MSB first, with no gap between bytes. Each bit is sampled on the system clock edge at which `sclk_o` rises.
- R5: `byte_cnt_i` (1 to 7) is captured at the start and sets the number of bytes read. A value of 0 is treated as 1. Changes to `byte_cnt_i` during a transaction have no effect.
- R6: `cs_n_o` rises in the cycle after the last data bit period ends. Byte k of the burst is placed in `data_o[8k+7:8k]`. Slots at or above the byte count keep their previous contents.
- R7: `cs_n_o` stays high, with `busy_o` still 1, for exactly `EXIT_CYC` cycles. `done_o` is then 1 for one cycle, in the same cycle that `busy_o` returns to 0.
- R8: `start_i` is ignored while `busy_o` is 1. A `start_i` that is high in the `done_o` cycle is accepted.
- R9: The block drives `sdio_io` only during the address phase. At all other times it leaves the line at high impedance for the sensor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a burst read |
| byte_cnt_i | input | 3 | Number of bytes to read (0 treated as 1) |
| cs_n_o | output | 1 | Active-low chip select to the sensor |
| sclk_o | output | 1 | Serial clock, idles high |
| sdio_io | inout | 1 | Bidirectional serial data line |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| data_o | output | 56 | Seven received byte slots, slot k at bits 8k+7:8k |

## Verification
The completion strobe and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising `start_i` in the very cycle its model predicts `done_o`. It then checks that the new chip-select low, clock and busy pattern starts one cycle later, and that the slots the shorter first burst wrote are still intact. A second overlap is the store of the final byte and the end of the data phase. This is judged by checking that every slot below the count matches the bytes the bench sensor sent, and that chip select rises on the exact cycle the model predicts.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SRAD,
    ST_DATA,
    ST_EXIT
  } rd_state_e;

  localparam int SLOTS = 7;
  localparam int BYTE_W = 8;

  // Requested byte count with the zero case folded onto one byte.
  function automatic logic [2:0] eff_count(input logic [2:0] req);
    return (req == 3'd0) ? 3'd1 : req;
  endfunction

  // Serial clock level for a given phase inside one bit period.
  function automatic logic phase_level(input int unsigned ph, input int unsigned half);
    return (ph >= half);
  endfunction

endpackage

// File: rtl/burst_rd_bitclk.sv
module burst_rd_bitclk #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic sample_evt,
  output logic bit_end_evt
);
  import burst_rd_pkg::*;

  localparam int PERIOD = 2 * HALF;
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!run || bit_end_evt) begin
      ph <= '0;
    end else begin
      ph <= ph + PW'(1);
    end
  end

  assign sample_evt  = run && (ph == PW'(HALF - 1));
  assign bit_end_evt = run && (ph == PW'(PERIOD - 1));
  assign sclk        = !run || phase_level(int'(ph), HALF);

endmodule

// File: rtl/burst_rd_timer.sv
module burst_rd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = arm && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!arm || hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/burst_rd_shifter.sv
module burst_rd_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic [W-1:0] next_q
);
  assign next_q = {q[W-2:0], sin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      q <= next_q;
    end
  end

endmodule

// File: rtl/burst_motion_reader.sv
module burst_motion_reader
  import burst_rd_pkg::*;
#(
  parameter int         SCLK_HALF  = 4,
  parameter int         SRAD_CYC   = 40,
  parameter int         EXIT_CYC   = 10,
  parameter logic [7:0] BURST_ADDR = 8'h63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [2:0]  byte_cnt_i,
  output logic        cs_n_o,
  output logic        sclk_o,
  inout  wire         sdio_io,
  output logic        busy_o,
  output logic        done_o,
  output logic [55:0] data_o
);

  localparam int TMAX = (SRAD_CYC > EXIT_CYC) ? SRAD_CYC : EXIT_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  rd_state_e st;
  logic [2:0] nbytes, bitc, idx;
  logic run, sample_evt, bit_end_evt, timer_arm, timer_hit;
  logic [TW-1:0] limit;
  logic sh_load, sh_en, sh_sin;
  logic [BYTE_W-1:0] sh_q, sh_next;
  logic addr_phase, srad_wait, data_phase, exit_wait;
  logic byte_store, last_bit, last_byte, sdio_oe;
  logic [SLOTS-1:0][BYTE_W-1:0] store;

  // Named phase and event wires
  assign addr_phase = (st == ST_ADDR);
  assign srad_wait  = (st == ST_SRAD);
  assign data_phase = (st == ST_DATA);
  assign exit_wait  = (st == ST_EXIT);
  assign run        = addr_phase || data_phase;
  assign timer_arm  = srad_wait || exit_wait;
  assign limit      = srad_wait ? TW'(SRAD_CYC) : TW'(EXIT_CYC);
  assign last_bit   = (bitc == 3'd7);
  assign last_byte  = (idx == nbytes - 3'd1);
  assign sh_load    = (st == ST_IDLE) && start_i;
  assign sh_en      = (addr_phase && bit_end_evt) || (data_phase && sample_evt);
  assign sh_sin     = data_phase ? sdio_io : 1'b0;
  assign byte_store = data_phase && sample_evt && last_bit;
  assign sdio_oe    = addr_phase;

  assign sdio_io = sdio_oe ? sh_q[BYTE_W-1] : 1'bz;
  assign cs_n_o  = (st == ST_IDLE) || exit_wait;
  assign busy_o  = (st != ST_IDLE);
  assign data_o  = store;

  burst_rd_bitclk #(.HALF(SCLK_HALF)) u_bitclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .sclk       (sclk_o),
    .sample_evt (sample_evt),
    .bit_end_evt(bit_end_evt)
  );

  burst_rd_timer #(.W(TW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (timer_arm),
    .limit(limit),
    .hit  (timer_hit)
  );

  burst_rd_shifter #(.W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .load_val(BURST_ADDR),
    .shift   (sh_en),
    .sin     (sh_sin),
    .q       (sh_q),
    .next_q  (sh_next)
  );

  // One register per result slot, written in arrival order
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store[s] <= '0;
      end else if (byte_store && (idx == 3'(s))) begin
        store[s] <= sh_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      nbytes <= 3'd1;
      bitc   <= '0;
      idx    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          st     <= ST_ADDR;
          nbytes <= eff_count(byte_cnt_i);
          bitc   <= '0;
          idx    <= '0;
        end
        ST_ADDR: if (bit_end_evt) begin
          bitc <= bitc + 3'd1;
          if (last_bit) st <= ST_SRAD;
        end
        ST_SRAD: if (timer_hit) st <= ST_DATA;
        ST_DATA: if (bit_end_evt) begin
          bitc <= bitc + 3'd1;
          if (last_bit) begin
            if (last_byte) st <= ST_EXIT;
            else           idx <= idx + 3'd1;
          end
        end
        ST_EXIT: if (timer_hit) begin
          st     <= ST_IDLE;
          done_o <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_rd_chk.sv
module burst_rd_chk #(
  parameter int SRAD_CYC = 40,
  parameter int EXIT_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o,
  input logic srad_wait,
  input logic exit_wait,
  input logic timer_hit,
  input logic byte_store,
  input logic sample_evt,
  input logic sdio_oe
);
  int unsigned scnt, xcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= 0;
      xcnt <= 0;
    end else begin
      scnt <= srad_wait ? scnt + 1 : 0;
      xcnt <= (busy_o && cs_n_o) ? xcnt + 1 : 0;
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && sclk_o));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && !cs_n_o));

  assert_srad_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    srad_wait |-> (sclk_o && !cs_n_o));

  assert_srad_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (srad_wait && timer_hit) |-> (scnt == SRAD_CYC - 1));

  assert_sample_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (!sclk_o ##1 sclk_o));

  assert_store_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_store |-> !cs_n_o);

  assert_exit_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (xcnt == EXIT_CYC));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && cs_n_o));

  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !exit_wait) |=> busy_o);

  assert_sdio_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (!cs_n_o && !srad_wait && !exit_wait));

endmodule

bind burst_motion_reader burst_rd_chk #(
  .SRAD_CYC(SRAD_CYC),
  .EXIT_CYC(EXIT_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .cs_n_o    (cs_n_o),
  .sclk_o    (sclk_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .srad_wait (srad_wait),
  .exit_wait (exit_wait),
  .timer_hit (timer_hit),
  .byte_store(byte_store),
  .sample_evt(sample_evt),
  .sdio_oe   (sdio_oe)
);

// File: tb/tb_burst_motion_reader.sv
module tb_burst_motion_reader;

  localparam int H    = 4;
  localparam int S    = 40;
  localparam int X    = 10;
  localparam logic [7:0] ADDR = 8'h63;
  localparam int A    = 16 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] byte_cnt = 3'd0;
  logic cs_n, sclk, busy, done;
  logic [55:0] data;
  wire sdio;
  logic tb_oe = 1'b0;
  logic tb_bit = 1'b0;

  assign sdio = tb_oe ? tb_bit : 1'bz;

  always #5 clk = ~clk;

  burst_motion_reader #(
    .SCLK_HALF(H), .SRAD_CYC(S), .EXIT_CYC(X), .BURST_ADDR(ADDR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_cnt_i(byte_cnt),
    .cs_n_o(cs_n), .sclk_o(sclk), .sdio_io(sdio), .busy_o(busy),
    .done_o(done), .data_o(data)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model state
  bit m_act = 0;
  bit m_done = 0;
  int m_t = 0;
  int m_n = 1;
  logic [7:0] sens [7];
  logic [7:0] exp_store [7];
  logic [7:0] cap = '0;

  function automatic int total(input int n);
    return A + S + n * 16 * H + X;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_act = 0;
      m_t = 0;
      for (int k = 0; k < 7; k++) exp_store[k] = '0;
    end else if (m_act) begin
      m_t++;
      if (m_t == total(m_n)) begin
        m_act = 0;
        m_done = 1;
      end
    end else if (start) begin
      m_act = 1;
      m_t = 0;
      m_n = (byte_cnt == 3'd0) ? 1 : int'(byte_cnt);
      for (int k = 0; k < 7; k++) sens[k] = 8'($urandom);
      cap = '0;
    end
  end

  // Per-cycle comparison, sensor model and address capture
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_cs, e_sclk;
      string tag;
      e_cs = 1'b1; e_sclk = 1'b1; tag = "R1";
      tb_oe = 1'b0;
      if (m_act) begin
        if (m_t < A) begin
          e_cs = 0; e_sclk = ((m_t % (2 * H)) >= H); tag = "R2";
          if ((m_t % (2 * H)) == H) cap = {cap[6:0], sdio};
        end else if (m_t < A + S) begin
          e_cs = 0; e_sclk = 1; tag = "R3";
        end else if (m_t < A + S + m_n * 16 * H) begin
          int b;
          b = m_t - A - S;
          e_cs = 0; e_sclk = ((b % (2 * H)) >= H); tag = "R4";
          b = b / (2 * H);
          tb_oe = 1'b1;
          tb_bit = sens[b / 8][7 - (b % 8)];
        end else begin
          tag = "R7";
        end
      end
      chk(tag, "cs_n", 64'(cs_n), 64'(e_cs));
      chk(tag, "sclk", 64'(sclk), 64'(e_sclk));
      chk(tag, "busy", 64'(busy), 64'(m_act));
      chk("R7", "done", 64'(done), 64'(m_done));
      if (m_done) begin
        for (int k = 0; k < m_n; k++) exp_store[k] = sens[k];
        for (int k = 0; k < 7; k++)
          chk("R6", $sformatf("slot%0d", k), 64'(data[8*k +: 8]), 64'(exp_store[k]));
        chk("R2", "address", 64'(cap), 64'(ADDR));
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!m_done);
  endtask

  task automatic burst(input logic [2:0] n);
    @(negedge clk);
    start = 1'b1;
    byte_cnt = n;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "data after reset", 64'(data), 64'(0));
    chk("R1", "cs idle", 64'(cs_n), 64'(1));
    burst(3'd7);                       // R4 full report
    burst(3'd1);                       // R5 single byte
    burst(3'd0);                       // R5 zero folded to one
    burst(3'd4);
    // R8 and R5: start and count changes while busy are ignored
    @(negedge clk); start = 1'b1; byte_cnt = 3'd2;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1; byte_cnt = 3'd7;
    @(negedge clk); start = 1'b0; byte_cnt = 3'd6;
    wait_done();
    // R8: new request in the done cycle, shorter burst keeps upper slots (R6)
    burst(3'd6);
    @(negedge clk); start = 1'b1; byte_cnt = 3'd3;
    @(negedge clk); start = 1'b0;
    wait_done();
    start = 1'b1; byte_cnt = 3'd5;
    @(negedge clk); start = 1'b0;
    chk("R8", "busy after done-cycle start", 64'(busy), 64'(1));
    wait_done();
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

endmodule